// File: doc/BRIEF.md
# Segment Table Address Translator

This block converts a two-part logical address into a physical one. A request carries a segment number and an offset. The segment number picks one entry of a small table kept in registers inside the block. Each entry holds a start address and a length. The block adds the offset to the start address, but only after two tests pass. The first test needs the segment number to lie below a programmable count of live entries. The second needs the offset to lie below the entry's length. A failure of either test raises a trap code instead of an address, and each failure has its own code.

A configuration port writes the start address or the length of any entry, and it writes the live-entry count. A context switch therefore costs only a rewrite of the count and of the entries it needs. The live-entry count clears on reset, so every request traps until software sets it. Results are registered. A request is accepted on any cycle, its result appears one cycle later, and requests can follow each other on every cycle.

Top module: `seg_xlate`

## Requirements
- R1: While reset is active and in the cycle after it is released, `done`, `pa_valid` and `fault` are 0 and `pa` is 0. The live-entry count resets to 0, so every request after reset reports the illegal-segment code 2'b01 until the count is written.
- R2: Each cycle with `req_valid` high produces `done` high in the following cycle, and that holds for back-to-back requests on consecutive cycles.
- R3: A request whose segment number is greater than or equal to the live-entry count yields `fault` = 2'b01, `pa_valid` = 0 and `pa` = 0.
- R4: A request with a legal segment whose offset is strictly below the entry's length yields `pa_valid` = 1, `fault` = 2'b00 and `pa` = start + offset, taken modulo 2^PA_W.
- R5: A request with a legal segment whose offset is greater than or equal to the entry's length yields `fault` = 2'b10, `pa_valid` = 0 and `pa` = 0. This includes an offset equal to the length and an entry whose length is 0.
- R6: When the segment is illegal and the offset also exceeds the length, the illegal-segment code 2'b01 is reported.
- R7: A configuration write with `cfg_we` = 1 uses `cfg_sel` 2'b00 to write the start address of entry `cfg_idx`, 2'b01 to write its length, and 2'b10 to write the live-entry count. A write with `cfg_sel` = 2'b11, or a start or length write with `cfg_idx` at or above ENTRIES, changes no state.
- R8: Writing a live-entry count larger than ENTRIES stores ENTRIES.
- R9: A request in the same cycle as a configuration write is translated with the table contents from before that write. The write takes effect for the requests that follow.
- R10: In the cycle after a cycle without a request, `done`, `pa_valid`, `fault` and `pa` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A translation request is present this cycle |
| req_seg | input | SNUM_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 00 start, 01 length, 10 live-entry count, 11 none |
| cfg_idx | input | SNUM_W | Entry written by a start or length write |
| cfg_data | input | DATA_W | Value written |
| done | output | 1 | A result is presented this cycle |
| pa_valid | output | 1 | The physical address is valid |
| pa | output | PA_W | Physical address, 0 unless `pa_valid` |
| fault | output | 2 | 00 none, 01 illegal segment, 10 offset past length |

## Verification
The bench builds the block with its default parameters: 8 entries, a 4-bit segment number and 32-bit addresses, offsets and lengths. Because the segment field is wider than the table, the bench can send segment numbers 8 to 15. These reach the count clamp and the ignored writes to entries that do not exist. The 32-bit start and offset let the bench reach the wrap of the sum at 2^32. Lengths can be set to 0 or to the largest value, which reaches both extremes of the limit test.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_SEG   = 2'b01,
      FLT_LIMIT = 2'b10
   } fault_e;

   typedef enum logic [1:0] {
      CFG_BASE  = 2'b00,
      CFG_LIMIT = 2'b01,
      CFG_LEN   = 2'b10,
      CFG_RSVD  = 2'b11
   } cfg_sel_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int ENTRIES = 8,
   parameter int SNUM_W  = 4,
   parameter int BASE_W  = 32,
   parameter int LIMIT_W = 32,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_base,
   input  logic               wr_limit,
   input  logic [SNUM_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [SNUM_W-1:0]  rd_idx,
   output logic [BASE_W-1:0]  rd_base,
   output logic [LIMIT_W-1:0] rd_limit
);

   localparam int BASE_BITS  = ENTRIES * BASE_W;
   localparam int LIMIT_BITS = ENTRIES * LIMIT_W;
   localparam int FULL_MAP   = (ENTRIES == (1 << SNUM_W)) ? 1 : 0;

   logic [BASE_BITS-1:0]  base_flat;
   logic [LIMIT_BITS-1:0] limit_flat;

   // one start/length pair per entry
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam logic [SNUM_W-1:0] MY_IDX = SNUM_W'(i);
      logic [BASE_W-1:0]  b_q;
      logic [LIMIT_W-1:0] l_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_q <= '0;
            l_q <= '0;
         end else begin
            if (wr_base && (wr_idx == MY_IDX)) begin
               b_q <= wr_data[BASE_W-1:0];
            end
            if (wr_limit && (wr_idx == MY_IDX)) begin
               l_q <= wr_data[LIMIT_W-1:0];
            end
         end
      end

      assign base_flat[i*BASE_W +: BASE_W]    = b_q;
      assign limit_flat[i*LIMIT_W +: LIMIT_W] = l_q;
   end

   // read port: direct slice when every index names an entry, scan otherwise
   if (FULL_MAP == 1) begin : g_rd_direct
      assign rd_base  = base_flat[rd_idx*BASE_W +: BASE_W];
      assign rd_limit = limit_flat[rd_idx*LIMIT_W +: LIMIT_W];
   end else begin : g_rd_scan
      always_comb begin
         rd_base  = '0;
         rd_limit = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (rd_idx == SNUM_W'(i)) begin
               rd_base  = base_flat[i*BASE_W +: BASE_W];
               rd_limit = limit_flat[i*LIMIT_W +: LIMIT_W];
            end
         end
      end
   end

endmodule

// File: rtl/seg_len_reg.sv
module seg_len_reg #(
   parameter int ENTRIES = 8,
   parameter int LEN_W   = 4,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [LEN_W-1:0]  len_q
);

   localparam logic [DATA_W-1:0] CAP_WIDE = DATA_W'(ENTRIES);
   localparam logic [LEN_W-1:0]  CAP      = LEN_W'(ENTRIES);

   logic [LEN_W-1:0] len_d;

   always_comb begin
      if (wr_data > CAP_WIDE) begin
         len_d = CAP;
      end else begin
         len_d = wr_data[LEN_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (wr_en) begin
         len_q <= len_d;
      end
   end

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int SNUM_W  = 4,
   parameter int LEN_W   = 4,
   parameter int OFF_W   = 32,
   parameter int LIMIT_W = 32,
   parameter int PA_W    = 32
) (
   input  logic [SNUM_W-1:0]  seg,
   input  logic [OFF_W-1:0]   off,
   input  logic [LEN_W-1:0]   len,
   input  logic [PA_W-1:0]    base,
   input  logic [LIMIT_W-1:0] limit,
   output fault_e             flt,
   output logic [PA_W-1:0]    sum
);

   localparam int SCW = (SNUM_W > LEN_W) ? SNUM_W : LEN_W;
   localparam int LCW = (OFF_W > LIMIT_W) ? OFF_W : LIMIT_W;

   logic          seg_ok;
   logic          off_ok;
   logic [PA_W-1:0] off_ext;

   assign seg_ok = SCW'(seg) < SCW'(len);
   assign off_ok = LCW'(off) < LCW'(limit);

   // fit the offset to the address width
   if (OFF_W >= PA_W) begin : g_off_trunc
      assign off_ext = off[PA_W-1:0];
   end else begin : g_off_zext
      assign off_ext = {{(PA_W-OFF_W){1'b0}}, off};
   end

   assign sum = base + off_ext;

   // segment legality outranks the length test
   always_comb begin
      if (!seg_ok) begin
         flt = FLT_SEG;
      end else if (!off_ok) begin
         flt = FLT_LIMIT;
      end else begin
         flt = FLT_NONE;
      end
   end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int SNUM_W  = 4,
   parameter int OFF_W   = 32,
   parameter int LIMIT_W = 32,
   parameter int PA_W    = 32,
   parameter int DATA_W  = 32,
   localparam int LEN_W  = $clog2(ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SNUM_W-1:0] req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [SNUM_W-1:0] cfg_idx,
   input  logic [DATA_W-1:0] cfg_data,
   output logic              done,
   output logic              pa_valid,
   output logic [PA_W-1:0]   pa,
   output logic [1:0]        fault
);

   // parameter sanity at elaboration
   if (ENTRIES < 1 || ENTRIES > (1 << SNUM_W)) begin : g_bad_entries
      $error("seg_xlate: ENTRIES must be between 1 and 2**SNUM_W");
   end
   if (DATA_W < PA_W || DATA_W < LIMIT_W) begin : g_bad_data
      $error("seg_xlate: DATA_W must cover start and length widths");
   end
   if (DATA_W < LEN_W) begin : g_bad_len
      $error("seg_xlate: DATA_W must cover the live-entry count");
   end

   logic               wr_base;
   logic               wr_limit;
   logic               wr_len;
   logic [LEN_W-1:0]   len_q;
   logic [PA_W-1:0]    ent_base;
   logic [LIMIT_W-1:0] ent_limit;
   fault_e             chk_flt;
   logic [PA_W-1:0]    chk_sum;

   logic               done_q;
   logic               pav_q;
   logic [PA_W-1:0]    pa_q;
   fault_e             flt_q;

   assign wr_base  = cfg_we && (cfg_sel == CFG_BASE);
   assign wr_limit = cfg_we && (cfg_sel == CFG_LIMIT);
   assign wr_len   = cfg_we && (cfg_sel == CFG_LEN);

   seg_table #(
      .ENTRIES (ENTRIES),
      .SNUM_W  (SNUM_W),
      .BASE_W  (PA_W),
      .LIMIT_W (LIMIT_W),
      .DATA_W  (DATA_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_base  (wr_base),
      .wr_limit (wr_limit),
      .wr_idx   (cfg_idx),
      .wr_data  (cfg_data),
      .rd_idx   (req_seg),
      .rd_base  (ent_base),
      .rd_limit (ent_limit)
   );

   seg_len_reg #(
      .ENTRIES (ENTRIES),
      .LEN_W   (LEN_W),
      .DATA_W  (DATA_W)
   ) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_len),
      .wr_data (cfg_data),
      .len_q   (len_q)
   );

   seg_check #(
      .SNUM_W  (SNUM_W),
      .LEN_W   (LEN_W),
      .OFF_W   (OFF_W),
      .LIMIT_W (LIMIT_W),
      .PA_W    (PA_W)
   ) u_check (
      .seg   (req_seg),
      .off   (req_off),
      .len   (len_q),
      .base  (ent_base),
      .limit (ent_limit),
      .flt   (chk_flt),
      .sum   (chk_sum)
   );

   // result register: one cycle from request to answer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         pav_q  <= 1'b0;
         pa_q   <= '0;
         flt_q  <= FLT_NONE;
      end else begin
         done_q <= req_valid;
         if (req_valid) begin
            flt_q <= chk_flt;
            if (chk_flt == FLT_NONE) begin
               pav_q <= 1'b1;
               pa_q  <= chk_sum;
            end else begin
               pav_q <= 1'b0;
               pa_q  <= '0;
            end
         end else begin
            flt_q <= FLT_NONE;
            pav_q <= 1'b0;
            pa_q  <= '0;
         end
      end
   end

   assign done     = done_q;
   assign pa_valid = pav_q;
   assign pa       = pa_q;
   assign fault    = flt_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int ENTRIES = 8,
   parameter int SNUM_W  = 4,
   parameter int LEN_W   = 4,
   parameter int PA_W    = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [SNUM_W-1:0] req_seg,
   input logic [LEN_W-1:0]  len_q,
   input logic              done,
   input logic              pa_valid,
   input logic [PA_W-1:0]   pa,
   input logic [1:0]        fault
);

   localparam logic [LEN_W-1:0] CAP = LEN_W'(ENTRIES);

   assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!done && !pa_valid && fault == 2'b00 && pa == '0));

   assert_illegal_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_seg >= len_q)) |=> (fault == 2'b01 && !pa_valid));

   assert_valid_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pa_valid |-> (done && fault == 2'b00));

   assert_fault_blocks_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != 2'b00) |-> (!pa_valid && pa == '0 && done));

   assert_len_capped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= CAP);

endmodule

bind seg_xlate seg_xlate_chk #(
   .ENTRIES (ENTRIES),
   .SNUM_W  (SNUM_W),
   .LEN_W   (LEN_W),
   .PA_W    (PA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_seg   (req_seg),
   .len_q     (len_q),
   .done      (done),
   .pa_valid  (pa_valid),
   .pa        (pa),
   .fault     (fault)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;

   localparam int NENT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_seg = '0;
   logic [31:0] req_off = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_data = '0;
   logic        done;
   logic        pa_valid;
   logic [31:0] pa;
   logic [1:0]  fault;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    cmp_on = 1'b0;
   bit    ended = 1'b0;
   string phase_tag = "";

   // behavioural model state
   logic [31:0] m_base [NENT];
   logic [31:0] m_lim  [NENT];
   int          m_len = 0;
   logic        e_done = 1'b0;
   logic        e_pav = 1'b0;
   logic [31:0] e_pa = '0;
   logic [1:0]  e_flt = 2'b00;
   string       e_tag = "R1";

   seg_xlate uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_seg   (req_seg),
      .req_off   (req_off),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_idx   (cfg_idx),
      .cfg_data  (cfg_data),
      .done      (done),
      .pa_valid  (pa_valid),
      .pa        (pa),
      .fault     (fault)
   );

   always #10 clk = ~clk;

   // reference model, evaluated on each rising edge
   always @(posedge clk) begin
      int s;
      s = int'(req_seg);
      if (!rst_n) begin
         for (int i = 0; i < NENT; i++) begin
            m_base[i] = '0;
            m_lim[i]  = '0;
         end
         m_len  = 0;
         e_done = 1'b0;
         e_pav  = 1'b0;
         e_pa   = '0;
         e_flt  = 2'b00;
         e_tag  = "R1";
      end else begin
         e_done = req_valid;
         e_pav  = 1'b0;
         e_pa   = '0;
         e_flt  = 2'b00;
         e_tag  = "R10";
         if (req_valid) begin
            if (s >= m_len) begin
               e_flt = 2'b01;
               e_tag = "R3";
               if (s < NENT && req_off >= m_lim[s]) e_tag = "R6";
            end else if (req_off >= m_lim[s]) begin
               e_flt = 2'b10;
               e_tag = "R5";
            end else begin
               e_pav = 1'b1;
               e_pa  = m_base[s] + req_off;
               e_tag = "R4";
            end
         end
         if (phase_tag != "") e_tag = phase_tag;
         // writes land after the translation of this edge
         if (cfg_we) begin
            if (cfg_sel == 2'b00 && int'(cfg_idx) < NENT) m_base[cfg_idx[2:0]] = cfg_data;
            if (cfg_sel == 2'b01 && int'(cfg_idx) < NENT) m_lim[cfg_idx[2:0]] = cfg_data;
            if (cfg_sel == 2'b10) m_len = (cfg_data > 32'(NENT)) ? NENT : int'(cfg_data);
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (cmp_on && rst_n && !ended) begin
         n_checks++;
         if (done !== e_done) begin
            n_fail++;
            $display("FAIL R2 done actual=%0b expected=%0b at %0t", done, e_done, $time);
         end else if (pa_valid !== e_pav || pa !== e_pa || fault !== e_flt) begin
            n_fail++;
            $display("FAIL %s pa_valid/pa/fault actual=%0b/%h/%b expected=%0b/%h/%b at %0t",
                     e_tag, pa_valid, pa, fault, e_pav, e_pa, e_flt, $time);
         end
      end
   end

   task automatic cyc(input logic rv, input logic [3:0] s, input logic [31:0] o,
                      input logic we, input logic [1:0] sel, input logic [3:0] idx,
                      input logic [31:0] d, input string t);
      @(negedge clk);
      req_valid = rv;
      req_seg   = s;
      req_off   = o;
      cfg_we    = we;
      cfg_sel   = sel;
      cfg_idx   = idx;
      cfg_data  = d;
      phase_tag = t;
   endtask

   task automatic req(input logic [3:0] s, input logic [31:0] o, input string t);
      cyc(1'b1, s, o, 1'b0, 2'b00, 4'd0, 32'd0, t);
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [3:0] idx, input logic [31:0] d,
                      input string t);
      cyc(1'b0, 4'd0, 32'd0, 1'b1, sel, idx, d, t);
   endtask

   task automatic idle(input int n, input string t);
      for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'd0, 1'b0, 2'b00, 4'd0, 32'd0, t);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: outputs quiet during reset and just after
      repeat (3) @(negedge clk);
      n_checks++;
      if (done !== 1'b0 || pa_valid !== 1'b0 || fault !== 2'b00 || pa !== 32'd0) begin
         n_fail++;
         $display("FAIL R1 reset outputs actual=%0b/%0b/%b/%h expected=0/0/00/00000000",
                  done, pa_valid, fault, pa);
      end
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(2, "R1");
      // R1: count is 0 so the first request traps
      req(4'd0, 32'd0, "R1");
      idle(1, "");

      // R7: program every entry and the count
      for (int i = 0; i < NENT; i++) begin
         cfg(2'b00, 4'(i), 32'h1000_0000 + 32'(i) * 32'h0010_0000, "R7");
         cfg(2'b01, 4'(i), 32'h100 * 32'(i + 1), "R7");
      end
      cfg(2'b10, 4'd0, 32'd5, "R7");
      req(4'd1, 32'h4, "R7");

      // R4, R5, R3, R6 patterns
      req(4'd2, 32'h10, "R4");
      req(4'd2, 32'h2FF, "R4");
      req(4'd2, 32'h300, "R5");
      req(4'd5, 32'h0, "R3");
      req(4'd6, 32'hFFFF, "R6");
      req(4'd4, 32'h4FF, "R4");
      req(4'd0, 32'h0, "R4");
      idle(2, "R10");

      // R2: back-to-back stream of mixed outcomes
      for (int k = 0; k < 24; k++) req(4'(k % 8), 32'(k) * 32'h37, "R2");
      idle(3, "R10");

      // R8: oversized count is clamped
      cfg(2'b10, 4'd0, 32'd100, "R8");
      req(4'd7, 32'h1, "R8");
      req(4'd8, 32'h1, "R8");
      req(4'd15, 32'h0, "R8");
      cfg(2'b10, 4'd0, 32'd9, "R8");
      req(4'd8, 32'h0, "R8");
      req(4'd7, 32'h7FF, "R8");

      // R7: writes that must be ignored
      cfg(2'b00, 4'd8, 32'hDEAD_BEEF, "R7");
      cfg(2'b01, 4'd9, 32'h0, "R7");
      cfg(2'b11, 4'd0, 32'h0, "R7");
      req(4'd0, 32'h4, "R7");
      req(4'd0, 32'hFF, "R7");

      // R9: write and request in the same cycle
      cyc(1'b1, 4'd1, 32'h8, 1'b1, 2'b00, 4'd1, 32'h2000_0000, "R9");
      req(4'd1, 32'h8, "R9");
      cyc(1'b1, 4'd1, 32'h180, 1'b1, 2'b01, 4'd1, 32'h180, "R9");
      req(4'd1, 32'h180, "R9");

      // R4: sum wraps at 2^32
      cfg(2'b00, 4'd3, 32'hFFFF_FFF0, "R7");
      cfg(2'b01, 4'd3, 32'hFFFF_FFFF, "R7");
      req(4'd3, 32'h20, "R4");
      req(4'd3, 32'hFFFF_FFFE, "R4");
      req(4'd3, 32'hFFFF_FFFF, "R5");

      // R5: zero-length entry always traps
      cfg(2'b01, 4'd2, 32'h0, "R7");
      req(4'd2, 32'h0, "R5");
      idle(2, "R10");

      // R1: reset in mid-run clears the count
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      cfg_we = 1'b0;
      phase_tag = "R1";
      repeat (2) @(negedge clk);
      n_checks++;
      if (done !== 1'b0 || pa_valid !== 1'b0 || fault !== 2'b00) begin
         n_fail++;
         $display("FAIL R1 mid reset actual=%0b/%0b/%b expected=0/0/00", done, pa_valid, fault);
      end
      rst_n = 1'b1;
      req(4'd0, 32'h0, "R1");
      req(4'd7, 32'h0, "R1");
      idle(3, "R10");

      finish_run();
   end

endmodule